// File: doc/BRIEF.md
# Regulator Enable and Fault Supervisor

This block is the digital control for one voltage regulator channel. It works out whether the regulator should run from three inputs: a software enable bit, a select bit that hands control to an external enable pin, and that pin. The analog side reports its state through three comparator results, already synchronous to the block clock. These say whether the output is above the short-circuit level, above the undervoltage limit and below the overvoltage limit.

A short-circuit timer, built from a tick prescaler and a tick counter, measures one millisecond of continuous low output while the regulator is on. The same timer covers a rail that never comes up after enable and a rail that collapses during operation. When the timer expires, the regulator is latched off and a sticky short-circuit flag is raised. A live power-good bit reports output validity. Either undervoltage alone or the full window decides validity. Each change of validity can raise a sticky power-good flag, and the changes towards valid and towards invalid have masks of their own. Both flags are cleared by a one-cycle write-one-to-clear pulse.

Top module: `rail_guard`

## Requirements
- R1: While `sw_enable` is 0, `rail_on` is 0 whatever `pin_select` and `ext_enable` are.
- R2: With `sw_enable`=1 and `pin_select`=0, `rail_on` is 1 whatever `ext_enable` is, provided no short-circuit latch is held. This takes effect in the same cycle.
- R3: With `sw_enable`=1 and `pin_select`=1, `rail_on` follows `ext_enable`: 0 when low, 1 when high.
- R4: If `above_short` stays 0 for CLK_PER_TICK*TICKS_PER_MS consecutive cycles from the first cycle the rail is on, then `rail_on` drops to 0 and `short_flag` becomes 1 after that many rising edges. One edge earlier, `rail_on` is still 1 and `short_flag` is still 0.
- R5: The same count applies to a dip in operation. A single cycle with `above_short`=1 restarts the count, so two dips of one cycle less than the window never trip.
- R6: After a short-circuit trip, `rail_on` stays 0 even once `above_short` returns. It comes back only after the effective enable has gone to 0 and then to 1 again.
- R7: `pgood` = `rail_on` & `above_uv` & (`window_mode` ? `below_ov` : 1). `window_mode`=0 selects the undervoltage check only and 1 selects the full window. The masks have no effect on `pgood`.
- R8: A 0-to-1 change of `pgood` sets `pg_flag` at the next rising edge, unless `mask_rise`=1.
- R9: A 1-to-0 change of `pgood` while `rail_on` stays 1 sets `pg_flag`, unless `mask_fall`=1. A disable that turns `rail_on` off raises no flag.
- R10: A one-cycle pulse on `clear_short` or `clear_pg` clears the matching flag at the next edge. A new event in that same cycle wins and leaves the flag set. Flags otherwise hold their value.
- R11: During and right after reset, `rail_on`, `pgood`, `short_flag` and `pg_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_enable | input | 1 | Software enable bit |
| pin_select | input | 1 | 1 hands on/off control to `ext_enable` |
| ext_enable | input | 1 | External enable pin, already synchronised |
| above_short | input | 1 | Output is above the short-circuit level |
| above_uv | input | 1 | Output is above the undervoltage limit |
| below_ov | input | 1 | Output is below the overvoltage limit |
| window_mode | input | 1 | 0: undervoltage check only, 1: full window |
| mask_rise | input | 1 | Suppresses the flag when the output becomes valid |
| mask_fall | input | 1 | Suppresses the flag when the output becomes invalid |
| clear_short | input | 1 | Write-one-to-clear pulse for `short_flag` |
| clear_pg | input | 1 | Write-one-to-clear pulse for `pg_flag` |
| rail_on | output | 1 | Regulator run command |
| pgood | output | 1 | Live output validity |
| short_flag | output | 1 | Sticky short-circuit flag |
| pg_flag | output | 1 | Sticky power-good change flag |

## Verification
The bench sweeps every combination of the three enable inputs and every combination of the validity inputs and window mode. These sweeps catch a swapped priority between the software bit and the pin, and a window mode that lets an overvoltage through. It hits the timer one edge before and exactly at expiry, both at start-up and in a dip. A design off by one in either the prescaler or the tick counter, or one that does not restart on a brief recovery, misses that edge. It checks that a tripped rail does not come back when the output recovers, and that a disable raises no power-good flag. A wrong latch releases by itself and a wrong disable reports a spurious fault. It also drives clears that coincide with new events, which a clear-first flag would lose.

// File: rtl/rg_pkg.sv
// Package rg_pkg
// Shared helpers for the regulator supervisor. Assumes nothing beyond
// parameter values of at least one.
package rg_pkg;

    // Width of a counter holding 0 .. n-1, never less than one bit.
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Pair of validity transition events.
    typedef struct packed {
        logic rise;
        logic fall;
    } pg_evt_t;

endpackage

// File: rtl/rg_enable_ctl.sv
// Module rg_enable_ctl
// Resolves the effective enable from the software bit, the pin select and
// the pin. It holds the short-circuit lockout and the sticky short-circuit flag.
// Assumes all inputs are synchronous to clk. The lockout releases only while
// the effective enable is low.
module rg_enable_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_enable,
    input  logic pin_select,
    input  logic ext_enable,
    input  logic trip,
    input  logic clear_short,
    output logic rail_on,
    output logic short_flag
);
    logic eff_en;
    logic lock_q;

    // Effective enable: software bit gated by the pin when pin control is chosen.
    always_comb eff_en = sw_enable & (~pin_select | ext_enable);

    // Run command: enabled and not locked out.
    always_comb rail_on = eff_en & ~lock_q;

    // Lockout: set on a trip, released once the enable goes away.
    always_ff @(posedge clk) begin
        if (!rst_n)       lock_q <= 1'b0;
        else if (!eff_en) lock_q <= 1'b0;
        else if (trip)    lock_q <= 1'b1;
    end

    // Sticky fault flag: a trip outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)           short_flag <= 1'b0;
        else if (trip)        short_flag <= 1'b1;
        else if (clear_short) short_flag <= 1'b0;
    end
endmodule

// File: rtl/rg_short_timer.sv
// Module rg_short_timer
// Counts consecutive cycles of 'active' through a prescaler and a tick counter.
// It pulses 'expire' on the cycle that completes CLK_PER_TICK*TICKS_PER_MS
// active cycles. Any inactive cycle restarts both stages.
module rg_short_timer #(
    parameter int CLK_PER_TICK = 250,
    parameter int TICKS_PER_MS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expire
);
    import rg_pkg::*;

    localparam int PW = cnt_width(CLK_PER_TICK);
    localparam int TW = cnt_width(TICKS_PER_MS);
    localparam logic [PW-1:0] PRE_LAST  = PW'(CLK_PER_TICK - 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_MS - 1);

    logic [PW-1:0] pre_q;
    logic [TW-1:0] tick_q;
    logic          tick;

    // Prescaler wrap marks one tick.
    always_comb tick = active & (pre_q == PRE_LAST);

    // Expiry on the last cycle of the last tick.
    always_comb expire = tick & (tick_q == TICK_LAST);

    // Prescaler: runs only while active, restarts otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) pre_q <= '0;
        else if (tick)         pre_q <= '0;
        else                   pre_q <= pre_q + 1'b1;
    end

    // Tick counter: advances on each tick, restarts on inactivity or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) tick_q <= '0;
        else if (expire)       tick_q <= '0;
        else if (tick)         tick_q <= tick_q + 1'b1;
    end
endmodule

// File: rtl/rg_pg_monitor.sv
// Module rg_pg_monitor
// Derives live power-good from the comparators and the window mode. It
// detects validity transitions and keeps the sticky power-good flag.
// Assumes rail_on is the run command; a fall seen while the rail is off is
// treated as commanded and not reported.
module rg_pg_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic rail_on,
    input  logic above_uv,
    input  logic below_ov,
    input  logic window_mode,
    input  logic mask_rise,
    input  logic mask_fall,
    input  logic clear_pg,
    output logic pgood,
    output logic pg_flag
);
    import rg_pkg::*;

    logic    pg_q;
    pg_evt_t evt;
    logic    set_flag;

    // Validity: undervoltage only, or full window when selected.
    always_comb pgood = rail_on & above_uv & (~window_mode | below_ov);

    // Transitions against last cycle's validity.
    always_comb begin
        evt.rise = pgood & ~pg_q;
        evt.fall = ~pgood & pg_q & rail_on;
    end

    // Unmasked event sets the flag.
    always_comb set_flag = (evt.rise & ~mask_rise) | (evt.fall & ~mask_fall);

    // Previous validity for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pg_q <= 1'b0;
        else        pg_q <= pgood;
    end

    // Sticky flag: an event outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        pg_flag <= 1'b0;
        else if (set_flag) pg_flag <= 1'b1;
        else if (clear_pg) pg_flag <= 1'b0;
    end
endmodule

// File: rtl/rail_guard.sv
// Module rail_guard
// Top of the regulator supervisor: enable resolution with short-circuit
// lockout, the millisecond short-circuit timer and the power-good monitor.
// Assumes comparator inputs are synchronous and glitch-free at clk.
module rail_guard #(
    parameter int CLK_PER_TICK = 250,
    parameter int TICKS_PER_MS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_enable,
    input  logic pin_select,
    input  logic ext_enable,
    input  logic above_short,
    input  logic above_uv,
    input  logic below_ov,
    input  logic window_mode,
    input  logic mask_rise,
    input  logic mask_fall,
    input  logic clear_short,
    input  logic clear_pg,
    output logic rail_on,
    output logic pgood,
    output logic short_flag,
    output logic pg_flag
);
    logic sc_active;
    logic sc_expire;

    // Timer runs while the rail is commanded on but sits below the short level.
    always_comb sc_active = rail_on & ~above_short;

    rg_enable_ctl u_en (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_enable   (sw_enable),
        .pin_select  (pin_select),
        .ext_enable  (ext_enable),
        .trip        (sc_expire),
        .clear_short (clear_short),
        .rail_on     (rail_on),
        .short_flag  (short_flag)
    );

    rg_short_timer #(
        .CLK_PER_TICK (CLK_PER_TICK),
        .TICKS_PER_MS (TICKS_PER_MS)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (sc_active),
        .expire (sc_expire)
    );

    rg_pg_monitor u_pg (
        .clk         (clk),
        .rst_n       (rst_n),
        .rail_on     (rail_on),
        .above_uv    (above_uv),
        .below_ov    (below_ov),
        .window_mode (window_mode),
        .mask_rise   (mask_rise),
        .mask_fall   (mask_fall),
        .clear_pg    (clear_pg),
        .pgood       (pgood),
        .pg_flag     (pg_flag)
    );
endmodule

// File: rtl/rail_guard_chk.sv
// Module rail_guard_chk
// Property checks on the supervisor ports, bound into every rail_guard.
module rail_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic sw_enable,
    input logic pin_select,
    input logic ext_enable,
    input logic below_ov,
    input logic window_mode,
    input logic mask_rise,
    input logic mask_fall,
    input logic clear_short,
    input logic clear_pg,
    input logic rail_on,
    input logic pgood,
    input logic short_flag,
    input logic pg_flag
);
    // R1
    sw_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_enable |-> !rail_on);

    // R3
    pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_select && !ext_enable) |-> !rail_on);

    // R4
    trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(short_flag) |-> !rail_on);

    // R7
    pg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rail_on |-> !pgood);

    // R7
    pg_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (window_mode && !below_ov) |-> !pgood);

    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_rise && mask_fall && !pg_flag && !clear_pg) |=> !pg_flag);

    // R10
    short_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (short_flag && !clear_short) |=> short_flag);

    // R10
    pg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_flag && !clear_pg) |=> pg_flag);
endmodule

bind rail_guard rail_guard_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_enable   (sw_enable),
    .pin_select  (pin_select),
    .ext_enable  (ext_enable),
    .below_ov    (below_ov),
    .window_mode (window_mode),
    .mask_rise   (mask_rise),
    .mask_fall   (mask_fall),
    .clear_short (clear_short),
    .clear_pg    (clear_pg),
    .rail_on     (rail_on),
    .pgood       (pgood),
    .short_flag  (short_flag),
    .pg_flag     (pg_flag)
);

// File: tb/sim_rail_guard.sv
module sim_rail_guard;
    localparam int CPT = 4;
    localparam int TPM = 5;
    localparam int WIN = CPT * TPM;

    logic clk = 1'b0;
    logic rst_n;
    logic sw_enable, pin_select, ext_enable, above_short, above_uv, below_ov;
    logic window_mode, mask_rise, mask_fall, clear_short, clear_pg;
    logic rail_on, pgood, short_flag, pg_flag;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rail_guard #(.CLK_PER_TICK(CPT), .TICKS_PER_MS(TPM)) u0 (
        .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .pin_select(pin_select),
        .ext_enable(ext_enable), .above_short(above_short), .above_uv(above_uv),
        .below_ov(below_ov), .window_mode(window_mode), .mask_rise(mask_rise),
        .mask_fall(mask_fall), .clear_short(clear_short), .clear_pg(clear_pg),
        .rail_on(rail_on), .pgood(pgood), .short_flag(short_flag), .pg_flag(pg_flag)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic pulse_clear_pg();
        clear_pg = 1'b1; step(1); clear_pg = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        {sw_enable, pin_select, ext_enable, above_short, above_uv, below_ov} = '0;
        {window_mode, mask_rise, mask_fall, clear_short, clear_pg} = '0;
        @(negedge clk);
        step(3);
        // R11 reset state
        check("R11 rail_on", rail_on, 1'b0);
        check("R11 pgood", pgood, 1'b0);
        check("R11 short_flag", short_flag, 1'b0);
        check("R11 pg_flag", pg_flag, 1'b0);
        rst_n = 1'b1;
        step(1);

        // R1 R2 R3: exhaustive enable sweep, timer held idle
        above_short = 1'b1;
        for (int i = 0; i < 8; i++) begin
            sw_enable = i[2]; pin_select = i[1]; ext_enable = i[0];
            #1;
            check(i[2] == 0 ? "R1 enable" : (i[1] == 0 ? "R2 enable" : "R3 enable"),
                  rail_on, i[2] & (~i[1] | i[0]));
            step(1);
        end

        // R7: validity sweep with rail on, then with rail off
        sw_enable = 1'b1; pin_select = 1'b0; mask_rise = 1'b1; mask_fall = 1'b0;
        for (int i = 0; i < 8; i++) begin
            above_uv = i[2]; below_ov = i[1]; window_mode = i[0];
            #1;
            check("R7 pgood", pgood, i[2] & (~i[0] | i[1]));
            step(1);
        end
        sw_enable = 1'b0; above_uv = 1'b1; below_ov = 1'b1; #1;
        check("R7 pgood off", pgood, 1'b0);

        // R8 R9: masks and commanded disable
        window_mode = 1'b0; above_uv = 1'b0; mask_rise = 1'b0; mask_fall = 1'b0;
        sw_enable = 1'b1; step(1);
        pulse_clear_pg();
        check("R10 pg clear", pg_flag, 1'b0);
        mask_rise = 1'b1; above_uv = 1'b1; step(1);
        check("R8 rise masked", pg_flag, 1'b0);
        above_uv = 1'b0; step(1);
        check("R9 fall unmasked", pg_flag, 1'b1);
        pulse_clear_pg();
        mask_rise = 1'b0; above_uv = 1'b1; step(1);
        check("R8 rise unmasked", pg_flag, 1'b1);
        pulse_clear_pg();
        mask_fall = 1'b1; above_uv = 1'b0; step(1);
        check("R9 fall masked", pg_flag, 1'b0);
        mask_fall = 1'b0; above_uv = 1'b1; step(1);
        pulse_clear_pg();
        check("R10 pg clear again", pg_flag, 1'b0);
        sw_enable = 1'b0; step(1);
        check("R9 commanded disable", pg_flag, 1'b0);
        sw_enable = 1'b1; step(1);
        check("R8 rise on enable", pg_flag, 1'b1);
        pulse_clear_pg();
        clear_pg = 1'b1; above_uv = 1'b0; step(1); clear_pg = 1'b0;
        check("R10 event beats clear", pg_flag, 1'b1);
        pulse_clear_pg();

        // R4: start-up never reaches the short level
        sw_enable = 1'b0; above_short = 1'b0; step(1);
        sw_enable = 1'b1;
        step(WIN - 1);
        check("R4 before expiry on", rail_on, 1'b1);
        check("R4 before expiry flag", short_flag, 1'b0);
        step(1);
        check("R4 at expiry off", rail_on, 1'b0);
        check("R4 at expiry flag", short_flag, 1'b1);

        // R6: latch holds after recovery, released by an enable cycle
        above_short = 1'b1; step(3);
        check("R6 latched off", rail_on, 1'b0);
        sw_enable = 1'b0; step(1);
        sw_enable = 1'b1; #1;
        check("R6 re-enabled", rail_on, 1'b1);
        clear_short = 1'b1; step(1); clear_short = 1'b0;
        check("R10 short clear", short_flag, 1'b0);

        // R5: dips in operation through the pin path
        pin_select = 1'b1; ext_enable = 1'b1;
        above_short = 1'b0; step(WIN - 1);
        above_short = 1'b1; step(1);
        above_short = 1'b0; step(WIN - 1);
        check("R5 restart keeps on", rail_on, 1'b1);
        check("R5 restart no flag", short_flag, 1'b0);
        above_short = 1'b1; step(1);
        above_short = 1'b0; step(WIN - 1);
        clear_short = 1'b1; step(1); clear_short = 1'b0;
        check("R5 dip trips", rail_on, 1'b0);
        check("R10 trip beats clear", short_flag, 1'b1);
        ext_enable = 1'b0; step(1);
        ext_enable = 1'b1; above_short = 1'b1; #1;
        check("R6 pin cycle releases", rail_on, 1'b1);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule